// File: doc/BRIEF.md
# Two-Tier Warp Issue Scheduler

This block picks the warp that issues an instruction in each cycle on a multithreaded SIMT core. The warps are split between two pools. A small active pool holds the warps that may issue. A larger pending pool holds all the others. Arbitration looks only at the active pool, so the logic that picks a warp, and any state cached per warp, only has to cover a few warps.

A warp leaves the active pool in the same cycle that it issues an instruction marked as possibly long-latency. A pulse reports the warp id, so that per-warp cached operands can be flushed. The demoted warp then waits in the pending pool until its completion event arrives. A free active slot is refilled from the pending pool, one warp per cycle. The warp chosen is the one that has waited in the pending pool longest and is no longer blocked.

Top module: `tiered_warp_scheduler`

## Requirements
- R1: After reset, warps 0 to ACTIVE_SLOTS-1 are active and waiting on nothing. The remaining warps are pending, with none blocked, and their pending age order follows their id. The round-robin pointer starts so that warp 0 has first priority.
- R2: Only a warp that is in the active pool and has its `warp_ready` bit set can issue. The active pool never holds more than ACTIVE_SLOTS warps.
- R3: Among the eligible warps, the one issued is the first one found scanning upward in id order, with wrap-around, starting from the warp after the last one issued.
- R4: When `issue_long` is high in a cycle with `issue_valid` high, `desched_valid` is high in that same cycle and `desched_id` equals `issue_id`. From the next cycle on, that warp is no longer active.
- R5: A demoted warp is blocked until `wake_valid` arrives with its id. A wake for a warp that is not blocked has no effect.
- R6: If the active pool has a free slot at the start of a cycle and at least one pending warp is unblocked, exactly one such warp becomes active at that clock edge. It can then issue from the next cycle on. At most one warp is promoted per cycle.
- R7: If no active warp has its ready bit set, `issue_valid` and `desched_valid` are low, and `issue_id` and `desched_id` read 0.
- R8: The warp promoted is the unblocked pending warp that entered the pending pool earliest. Demoted warps join the pool in the order they were demoted, after all warps already in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_ready | input | NUM_WARPS | Per-warp bit: warp has an instruction ready this cycle |
| issue_long | input | 1 | The instruction issued this cycle may have long latency |
| wake_valid | input | 1 | A long-latency completion event is present |
| wake_id | input | $clog2(NUM_WARPS) | Warp whose long-latency operation completed |
| issue_valid | output | 1 | A warp issues this cycle |
| issue_id | output | $clog2(NUM_WARPS) | Id of the issuing warp, 0 when idle |
| desched_valid | output | 1 | The issuing warp is being demoted |
| desched_id | output | $clog2(NUM_WARPS) | Id of the demoted warp, 0 when none |

## Verification
The bench builds the block with 8 warps and 3 active slots. With a small pool, the pending pool is almost always non-empty and free slots appear after only a few demotions. Because there are few warps, round-robin wrap-around, a pool in which every warp is blocked, and promotion that skips a blocked warp ahead of it in the age order all occur many times in a few thousand cycles. Directed sequences set up spurious wakes, and wakes that land in the same cycle as a demotion.

// File: rtl/tiered_warp_scheduler.sv
module tiered_warp_scheduler #(
  parameter int NUM_WARPS    = 32,
  parameter int ACTIVE_SLOTS = 8,
  localparam int WID         = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WARPS-1:0] warp_ready,
  input  logic                 issue_long,
  input  logic                 wake_valid,
  input  logic [WID-1:0]       wake_id,
  output logic                 issue_valid,
  output logic [WID-1:0]       issue_id,
  output logic                 desched_valid,
  output logic [WID-1:0]       desched_id
);
  localparam int CW       = WID + 1;
  localparam int PEND_MIN = NUM_WARPS - ACTIVE_SLOTS;

  logic [NUM_WARPS-1:0] active_q, blocked_q;
  logic [WID-1:0]       age_q [NUM_WARPS];
  logic [CW-1:0]        pend_cnt_q;
  logic [WID-1:0]       last_q;

  logic [NUM_WARPS-1:0] elig;
  logic                 pick_ok;
  logic [WID-1:0]       pick_id;
  logic                 slot_free, cand_ok, promote, demote;
  logic [WID-1:0]       cand_pos;
  logic [WID-1:0]       age_n [NUM_WARPS];
  logic [CW-1:0]        cnt_mid;

  assign elig = active_q & warp_ready;

  always_comb begin
    pick_ok = 1'b0;
    pick_id = '0;
    for (int k = 1; k <= NUM_WARPS; k++) begin
      int idx;
      idx = (int'(last_q) + k) % NUM_WARPS;
      if (!pick_ok && elig[idx]) begin
        pick_ok = 1'b1;
        pick_id = WID'(idx);
      end
    end
  end

  assign issue_valid   = pick_ok;
  assign issue_id      = pick_id;
  assign demote        = pick_ok && issue_long;
  assign desched_valid = demote;
  assign desched_id    = demote ? pick_id : '0;

  assign slot_free = pend_cnt_q > CW'(PEND_MIN);

  always_comb begin
    cand_ok  = 1'b0;
    cand_pos = '0;
    for (int i = 0; i < NUM_WARPS; i++) begin
      if (!cand_ok && i < int'(pend_cnt_q) && !blocked_q[age_q[i]]) begin
        cand_ok  = 1'b1;
        cand_pos = WID'(i);
      end
    end
  end

  assign promote = slot_free && cand_ok;
  assign cnt_mid = pend_cnt_q - CW'(promote);

  always_comb begin
    for (int i = 0; i < NUM_WARPS; i++) begin
      if (promote && i >= int'(cand_pos) && i < NUM_WARPS - 1)
        age_n[i] = age_q[i+1];
      else
        age_n[i] = age_q[i];
    end
    if (demote)
      age_n[cnt_mid[WID-1:0]] = pick_id;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WARPS; i++) begin
        active_q[i] <= (i < ACTIVE_SLOTS);
        age_q[i]    <= (i < PEND_MIN) ? WID'(ACTIVE_SLOTS + i) : '0;
      end
      blocked_q  <= '0;
      pend_cnt_q <= CW'(PEND_MIN);
      last_q     <= WID'(NUM_WARPS - 1);
    end else begin
      for (int i = 0; i < NUM_WARPS; i++) begin
        age_q[i] <= age_n[i];
        if (promote && WID'(i) == age_q[cand_pos]) active_q[i] <= 1'b1;
        if (demote && WID'(i) == pick_id)          active_q[i] <= 1'b0;
        if (wake_valid && WID'(i) == wake_id && blocked_q[i]) blocked_q[i] <= 1'b0;
        if (demote && WID'(i) == pick_id)          blocked_q[i] <= 1'b1;
      end
      pend_cnt_q <= cnt_mid + CW'(demote);
      if (pick_ok) last_q <= pick_id;
    end
  end

  AST_POOL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(active_q) <= ACTIVE_SLOTS); // R2
  AST_POOL_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(active_q) + int'(pend_cnt_q) == NUM_WARPS); // R2
  AST_DEMOTED_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    desched_valid |=> !active_q[$past(desched_id)]); // R4
  AST_DEMOTED_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    desched_valid |=> blocked_q[$past(desched_id)]); // R5
  AST_NO_BLOCKED_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q & blocked_q) == '0); // R5
  AST_ONE_PROMOTION: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(active_q & ~$past(active_q)) <= 1); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (warp_ready & active_q) == '0 |-> !issue_valid && !desched_valid); // R7
endmodule

// File: tb/tiered_warp_scheduler_tb.sv
`timescale 1ns/1ps
module tiered_warp_scheduler_tb_top;
  localparam int NW  = 8;
  localparam int NA  = 3;
  localparam int WID = $clog2(NW);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NW-1:0] warp_ready = '0;
  logic issue_long = 1'b0, wake_valid = 1'b0;
  logic [WID-1:0] wake_id = '0;
  logic issue_valid, desched_valid;
  logic [WID-1:0] issue_id, desched_id;

  int checks = 0, errors = 0;
  bit m_act[NW], m_wait[NW];
  int m_q[$];
  int m_last;

  always #2.5 clk = ~clk;

  tiered_warp_scheduler #(.NUM_WARPS(NW), .ACTIVE_SLOTS(NA)) dut_i (
    .clk(clk), .rst_n(rst_n), .warp_ready(warp_ready), .issue_long(issue_long),
    .wake_valid(wake_valid), .wake_id(wake_id), .issue_valid(issue_valid),
    .issue_id(issue_id), .desched_valid(desched_valid), .desched_id(desched_id));

  task automatic check(string tag, string field, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, field, act, exp);
    end
  endtask

  task automatic model_reset();
    m_q.delete();
    for (int i = 0; i < NW; i++) begin
      m_act[i] = (i < NA);
      m_wait[i] = 0;
      if (i >= NA) m_q.push_back(i);
    end
    m_last = NW - 1;
  endtask

  task automatic step(string tag, logic [NW-1:0] rdy, bit lng, bit wv, int wid);
    bit ev;
    int eid, ac, pos;
    @(negedge clk);
    warp_ready = rdy; issue_long = lng; wake_valid = wv; wake_id = WID'(wid);
    #1;
    ev = 0; eid = 0;
    for (int k = 1; k <= NW; k++) begin
      int idx;
      idx = (m_last + k) % NW;
      if (!ev && m_act[idx] && rdy[idx]) begin ev = 1; eid = idx; end
    end
    check(tag, "issue_valid", int'(issue_valid), int'(ev));
    check(tag, "issue_id", int'(issue_id), eid);
    check({tag, " R4"}, "desched_valid", int'(desched_valid), int'(ev && lng));
    check({tag, " R4"}, "desched_id", int'(desched_id), (ev && lng) ? eid : 0);
    ac = 0;
    for (int i = 0; i < NW; i++) ac += int'(m_act[i]);
    pos = -1;
    if (ac < NA)
      for (int p = 0; p < m_q.size(); p++)
        if (pos < 0 && !m_wait[m_q[p]]) pos = p;
    if (pos >= 0) begin
      m_act[m_q[pos]] = 1;
      m_q.delete(pos);
    end
    if (wv && m_wait[wid]) m_wait[wid] = 0;
    if (ev && lng) begin
      m_act[eid] = 0;
      m_wait[eid] = 1;
      m_q.push_back(eid);
    end
    if (ev) m_last = eid;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step("R1 reset order", '1, 0, 0, 0);
    step("R1 R7 pending-only ready", 8'b1111_1000, 0, 0, 0);
    step("R7 none ready", '0, 0, 0, 0);
    for (int i = 0; i < 5; i++) step("R3 round robin", '1, 0, 0, 0);
    step("R3 sparse ready", 8'b0000_0101, 0, 0, 0);
    step("R3 sparse ready", 8'b0000_0101, 0, 0, 0);
    step("R4 demote", '1, 1, 0, 0);
    step("R6 R8 promote", '1, 0, 0, 0);
    step("R4 demote again", '1, 1, 0, 0);
    step("R5 wake same cycle as demote", '1, 1, 1, 2);
    for (int i = 0; i < 3; i++) step("R6 R8 refill", '1, 1, 0, 0);
    step("R5 spurious wake", '1, 0, 1, 3);
    for (int i = 0; i < 4; i++) step("R6 R8 all blocked", '1, 1, 0, 0);
    for (int w = 0; w < NW; w++) step("R5 R8 wake", '1, 0, 1, w);
    for (int i = 0; i < 4; i++) step("R6 R8 after wakes", '1, 0, 0, 0);
    for (int c = 0; c < 4000; c++) begin
      logic [NW-1:0] r;
      int wid;
      r = NW'($urandom);
      if ($urandom_range(0, 9) == 0) r = '0;
      wid = $urandom_range(0, NW - 1);
      step("R2 R3 R4 R5 R6 R8 random", r, ($urandom_range(0, 3) == 0),
           ($urandom_range(0, 2) == 0), wid);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule